// File: doc/BRIEF.md
# Timer Compare/Capture Pin Controller

This block is the general register of one timer channel together with the logic on that channel's pin. A 4-bit mode field chooses the register's role.

As an output-compare register, the block drives the pin from a level register. Writing the mode field loads a starting level. Each later equality between the free-running counter and the general register then clears, sets or toggles that level.

As an input-capture register, the block copies the counter value into the general register. The trigger is a synchronized edge on the pin, or a count pulse from a neighbouring channel's counter. The neighbour trigger is suppressed while that counter runs on the undivided clock.

The counter, the prescaler and interrupt generation sit outside the block. It sees them only through the counter value, the neighbour's count pulse and the neighbour's prescaler-select code.

Top module: `tmr_pin_ctl`

## Requirements
- R1: After reset the mode field and the general register read 0, and `pin_oe` and `pin_out` are 0.
- R2: A write with `wr_sel`=0 stores `wr_data[3:0]` as the mode field. A write with `wr_sel`=1 stores `wr_data` in the general register. `rd_data` shows the general register when `rd_sel`=1, and the zero-extended mode field when `rd_sel`=0.
- R3: With mode bit 3 at 0 and mode bits [1:0] at 00 (codes 0000 and 0100), and in every capture code (bit 3 at 1), `pin_oe` is 0 and `pin_out` is 0.
- R4: In an output-compare code with bits [1:0] not 00, `pin_oe` is 1. From the cycle after the mode write, `pin_out` equals mode bit 2 (the starting level), and it holds that level until a compare match.
- R5: When the counter equals the general register at a clock edge, the level changes at the following edge. Bits [1:0] of 01 drive it to 0 and bits [1:0] of 10 drive it to 1.
- R6: Bits [1:0] of 11 toggle the level on every compare match, with the same one-cycle delay.
- R7: Code 1000 captures on a rising pin edge, code 1001 on a falling edge, and codes 1010 and 1011 on either edge. The pin passes two synchronizing flops, so the counter value is captured at the third clock edge after the pin changes.
- R8: Codes 11xx capture the counter value at the clock edge where `nb_cnt_pulse` is 1, provided `nb_psel` is not 000.
- R9: In codes 11xx with `nb_psel` = 000, the general register never changes except by a write.
- R10: In output-compare codes the general register changes only by a write.
- R11: A general-register write at the same edge as a capture wins over the capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 = mode field, 1 = general register |
| wr_data | input | CW | Write data |
| rd_sel | input | 1 | Read source: 0 = mode field, 1 = general register |
| rd_data | output | CW | Read data |
| cnt_val | input | CW | Free-running counter value |
| pin_in | input | 1 | Timer pin input (asynchronous) |
| pin_out | output | 1 | Timer pin output value |
| pin_oe | output | 1 | Timer pin output enable |
| nb_cnt_pulse | input | 1 | Neighbour counter counted up or down this cycle |
| nb_psel | input | 3 | Neighbour prescaler select; 000 is the undivided clock |

## Verification
The results fall due at fixed delays after a stimulus:
- Register writes and the starting level show one edge after the write.
- A match action shows two edges after the counter is made equal to the general register.
- A pin-edge capture lands at the third edge after the pin moves.
- A neighbour-pulse capture lands at the very next edge.

The bench drives on the falling clock edge and counts exactly that many falling edges before it samples. For pin captures it also samples one edge early and expects the old value. This catches a missing or extra synchronizer stage. Every code and every prescaler select is swept, with expected levels and captured values computed from the code bits.

// File: rtl/tmr_pin_ctl.sv
module tmr_pin_ctl #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [CW-1:0] wr_data,
  input  logic          rd_sel,
  output logic [CW-1:0] rd_data,
  input  logic [CW-1:0] cnt_val,
  input  logic          pin_in,
  output logic          pin_out,
  output logic          pin_oe,
  input  logic          nb_cnt_pulse,
  input  logic [2:0]    nb_psel
);
  localparam int PADW = CW - 4;

  logic [3:0]    mode;
  logic [CW-1:0] greg;
  logic          lvl, match_q;
  logic          s1, s2, s3;

  wire mode_wr = wr_en && !wr_sel;
  wire greg_wr = wr_en && wr_sel;
  wire is_oc   = !mode[3];
  wire [1:0] act = is_oc ? mode[1:0] : 2'b00;
  wire rise = s2 && !s3;
  wire fall = !s2 && s3;

  logic cap;
  always_comb begin
    cap = 1'b0;
    if (mode[3]) begin
      case (mode[2:1])
        2'b00:   cap = mode[0] ? fall : rise;
        2'b01:   cap = rise || fall;
        default: cap = nb_cnt_pulse && (nb_psel != 3'b000);
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= pin_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode <= 4'b0000;
    else if (mode_wr) mode <= wr_data[3:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) greg <= '0;
    else if (greg_wr) greg <= wr_data;
    else if (cap) greg <= cnt_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) match_q <= 1'b0;
    else match_q <= (cnt_val == greg);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl <= 1'b0;
    else if (mode_wr) lvl <= wr_data[2];
    else if (match_q) begin
      case (act)
        2'b01:   lvl <= 1'b0;
        2'b10:   lvl <= 1'b1;
        2'b11:   lvl <= !lvl;
        default: lvl <= lvl;
      endcase
    end
  end

  assign pin_oe  = is_oc && (mode[1:0] != 2'b00);
  assign pin_out = pin_oe && lvl;
  assign rd_data = rd_sel ? greg : {{PADW{1'b0}}, mode};

  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |=> (mode == 4'b0000 && greg == '0 && !pin_oe));
  a_r3_quiet_pin: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_oe |-> !pin_out);
  a_r5_clear_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    (is_oc && mode[1:0] == 2'b01 && match_q && !mode_wr) |=> !lvl);
  a_r6_toggle_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    (is_oc && mode[1:0] == 2'b11 && match_q && !mode_wr) |=> (lvl != $past(lvl)));
  a_r9_no_capture_on_undivided: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[3:2] == 2'b11 && nb_psel == 3'b000 && !greg_wr) |=> $stable(greg));
  a_r10_oc_holds_register: assert property (@(posedge clk) disable iff (!rst_n)
    (is_oc && !greg_wr) |=> $stable(greg));
  a_r11_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    greg_wr |=> (greg == $past(wr_data)));
endmodule

// File: tb/tmr_pin_ctl_tb.sv
module tmr_pin_ctl_tb;
  localparam int CW = 16;
  localparam time TCLK = 10ns;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
  logic [CW-1:0] wr_data = '0, cnt_val = '0;
  logic          pin_in = 1'b0, nb_cnt_pulse = 1'b0;
  logic [2:0]    nb_psel = 3'b001;
  logic [CW-1:0] rd_data;
  logic          pin_out, pin_oe;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  tmr_pin_ctl #(.CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .cnt_val(cnt_val), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .nb_cnt_pulse(nb_cnt_pulse), .nb_psel(nb_psel)
  );

  always #(TCLK/2) clk = ~clk;

  task automatic chk(input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [CW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_greg(output logic [CW-1:0] v);
    rd_sel = 1'b1; #1; v = rd_data;
  endtask

  initial begin
    logic [CW-1:0] v;
    repeat (3) @(negedge clk);
    rd_sel = 1'b0; #1;
    chk("R1 mode", rd_data, '0);
    rd_sel = 1'b1; #1;
    chk("R1 greg", rd_data, '0);
    chk("R1 oe/out", {14'd0, pin_oe, pin_out}, '0);
    rst_n = 1'b1;

    wr(1'b1, 16'h0040);
    rd_greg(v); chk("R2 greg readback", v, 16'h0040);
    wr(1'b0, 16'hFFF9);
    rd_sel = 1'b0; #1; chk("R2 mode readback", rd_data, 16'h0009);

    for (int code = 0; code < 8; code++) begin
      logic en, l;
      wr(1'b1, 16'h0040);
      cnt_val = 16'h0001;
      wr(1'b0, CW'(code));
      en = (code[1:0] != 2'b00);
      l  = code[2];
      chk($sformatf("R4/R3 oe code %0d", code), {15'd0, pin_oe}, {15'd0, en});
      chk($sformatf("R4 start level code %0d", code), {15'd0, pin_out}, {15'd0, en & l});
      for (int m = 0; m < 2; m++) begin
        @(negedge clk); cnt_val = 16'h0040;
        @(negedge clk); cnt_val = 16'h0002 + CW'(m);
        @(negedge clk);
        case (code[1:0])
          2'b01: l = 1'b0;
          2'b10: l = 1'b1;
          2'b11: l = ~l;
          default: l = l;
        endcase
        chk($sformatf("R5/R6 match %0d code %0d", m, code), {15'd0, pin_out}, {15'd0, en & l});
      end
      rd_greg(v); chk($sformatf("R10 greg kept code %0d", code), v, 16'h0040);
    end

    for (int code = 8; code < 12; code++) begin
      for (int e = 0; e < 2; e++) begin
        logic trig;
        logic [CW-1:0] cv;
        pin_in = (e == 1);
        wr(1'b0, CW'(code));
        repeat (4) @(negedge clk);
        chk($sformatf("R3 oe capture code %0d", code), {14'd0, pin_oe, pin_out}, '0);
        wr(1'b1, 16'hFFFF);
        cv = CW'(16'h1000 + code * 16 + e);
        cnt_val = cv;
        pin_in = ~pin_in;
        trig = (code >= 10) || (code == 8 && e == 0) || (code == 9 && e == 1);
        repeat (2) @(negedge clk);
        rd_greg(v); chk($sformatf("R7 early code %0d edge %0d", code, e), v, 16'hFFFF);
        @(negedge clk);
        rd_greg(v); chk($sformatf("R7 capture code %0d edge %0d", code, e), v, trig ? cv : 16'hFFFF);
      end
    end

    pin_in = 1'b0;
    for (int code = 12; code < 16; code++) begin
      wr(1'b0, CW'(code));
      for (int ps = 0; ps < 8; ps++) begin
        logic [CW-1:0] cv;
        wr(1'b1, 16'hABCD);
        nb_psel = 3'(ps);
        cv = CW'(16'h2000 + code * 8 + ps);
        cnt_val = cv;
        repeat (2) @(negedge clk);
        rd_greg(v); chk($sformatf("R9 idle code %0d ps %0d", code, ps), v, 16'hABCD);
        nb_cnt_pulse = 1'b1;
        @(negedge clk);
        nb_cnt_pulse = 1'b0;
        rd_greg(v);
        chk($sformatf("R8/R9 pulse code %0d ps %0d", code, ps), v, (ps != 0) ? cv : 16'hABCD);
      end
    end

    nb_psel = 3'b010;
    cnt_val = 16'h3333;
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 1'b1; wr_data = 16'h5A5A; nb_cnt_pulse = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; nb_cnt_pulse = 1'b0;
    rd_greg(v); chk("R11 write beats capture", v, 16'h5A5A);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule